// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block raises interrupts for one eight-pin GPIO port. It watches the port's pin inputs, which are already synchronized to the clock. For every pin it records a pending status bit according to a trigger type chosen per pin: rising edge, falling edge, either edge, high level or low level. The port interrupt line is high whenever some pin has both its status bit and its enable bit set.

Software reaches the block through a simple 32-bit register port. Reads are combinational and writes take effect on a single strobe. The port has four interrupt registers: a read-only status register, an enable register, a 24-bit trigger-type register and a write-one-to-clear register. The trigger type of pin n is held in three bit-planes of the type register:
- bit n gives the polarity (rising or high);
- bit 8+n selects edge operation;
- bit 16+n selects both edges.

A masked alias of the enable register lets software change single enable bits without a read-modify-write.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, reads of status, enable and type return 0 and `irq_o` is 0. Reset leaves every pin disabled and in level-low type.
- R2: Register offsets are as follows:
  - status at 0x040, read-only; writes to it change nothing.
  - enable at 0x050, read/write, bits 7:0.
  - type at 0x060, read/write, bits 23:0.
  - clear at 0x070, write-only; it reads as 0.
  - Any other offset reads as 0, and writes to it change no register.
- R3: With type bits 8+n and n set and bit 16+n clear (rising), a 0-to-1 change of pin n sets status bit n one clock later.
- R4: With only type bit 8+n set (falling), a 1-to-0 change of pin n sets status bit n one clock later, and a 0-to-1 change does not.
- R5: With type bits 16+n and 8+n set (both edges), either change of pin n sets status bit n one clock later.
- R6: In edge mode a status bit stays set until a write of 1 to bit n of the clear register at 0x070. Zero bits of that write leave their status bits as they are.
- R7: If a selected edge and a clear of the same pin fall in the same cycle, the status bit is set after that cycle.
- R8: In level mode (type bit 8+n clear), status bit n equals the active level one clock later:
  - type bit n set means high-active;
  - type bit n clear means low-active.
  A clear has no lasting effect while the level is active.
- R9: Status is recorded whether or not the pin is enabled. `irq_o` is the OR over all pins of status AND enable.
- R10: A write to offset 0x850 updates enable bit k to data bit k only where data bit 8+k is 1. Other enable bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | 8 | Synchronized pin levels |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Register byte offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational while `acc_en` is high |
| irq_o | output | 1 | Port interrupt |

## Verification
The assertions assume that `pin_i` is already synchronous to `clk`, so a change seen at one edge is a real transition. They also assume that the access strobe is driven away from the clock edge and holds stable through it. The bench changes pins and access signals only on the falling clock edge. It raises at most one access per cycle, and it lets a type change settle for a cycle before it counts on the new mode. The same-cycle edge and clear case is produced on purpose by driving the pin change and the clear strobe at the same falling edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_STATUS     = 12'h040;
    localparam logic [OFS_W-1:0] OFS_ENABLE     = 12'h050;
    localparam logic [OFS_W-1:0] OFS_TYPE       = 12'h060;
    localparam logic [OFS_W-1:0] OFS_CLEAR      = 12'h070;
    localparam logic [OFS_W-1:0] OFS_ENABLE_MSK = 12'h850;

    typedef enum logic [2:0] {
        TRIG_LVL_LO = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_FALL   = 3'd2,
        TRIG_RISE   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    // Edge select dominates; within edge mode the both-edges plane wins over
    // polarity. In level mode the both-edges plane is ignored.
    function automatic trig_e trig_decode(logic is_edge, logic pol, logic both);
        trig_e m;
        if (!is_edge)  m = pol ? TRIG_LVL_HI : TRIG_LVL_LO;
        else if (both) m = TRIG_BOTH;
        else           m = pol ? TRIG_RISE : TRIG_FALL;
        return m;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg #(
    parameter int unsigned NPIN   = 8,
    localparam int unsigned TYPE_W = 3 * NPIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_mwr,
    input  logic              type_wr,
    input  logic [NPIN-1:0]   en_val,
    input  logic [NPIN-1:0]   en_mask,
    input  logic [TYPE_W-1:0] type_val,
    output logic [NPIN-1:0]   enable_o,
    output logic [TYPE_W-1:0] trig_o
);

    typedef struct packed {
        logic [NPIN-1:0]   en;
        logic [TYPE_W-1:0] trig;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (en_wr) begin
            cfg_d.en = en_val;
        end else if (en_mwr) begin
            cfg_d.en = (cfg_q.en & ~en_mask) | (en_val & en_mask);
        end
        if (type_wr) begin
            cfg_d.trig = type_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign enable_o = cfg_q.en;
    assign trig_o   = cfg_q.trig;

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic is_edge,
    input  logic pol,
    input  logic both,
    input  logic clr,
    output logic status_o,
    output logic prev_o
);

    typedef struct packed {
        logic prev;
        logic status;
    } pin_st_t;

    pin_st_t st_d, st_q;
    trig_e   mode;
    logic    rise, fall, hit;

    always_comb begin
        mode = trig_decode(is_edge, pol, both);
        rise = pin_i & ~st_q.prev;
        fall = ~pin_i & st_q.prev;
        hit  = 1'b0;
        st_d = st_q;
        st_d.prev = pin_i;
        unique case (mode)
            TRIG_LVL_LO: st_d.status = ~pin_i;
            TRIG_LVL_HI: st_d.status = pin_i;
            TRIG_FALL:   hit = fall;
            TRIG_RISE:   hit = rise;
            TRIG_BOTH:   hit = rise | fall;
            default:     hit = 1'b0;
        endcase
        if (is_edge) begin
            // new edge beats a same-cycle clear
            st_d.status = hit | (st_q.status & ~clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign prev_o   = st_q.prev;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN   = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_i,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              irq_o
);

    localparam int unsigned TYPE_W = 3 * NPIN;

    logic              wr, rd;
    logic              sel_status, sel_en, sel_type, sel_clr, sel_enm;
    logic [NPIN-1:0]   clr_vec;
    logic [NPIN-1:0]   enable_q;
    logic [TYPE_W-1:0] trig_q;
    logic [NPIN-1:0]   status_q;
    logic [NPIN-1:0]   pin_prev;
    logic              unused_wdata;

    assign unused_wdata = ^acc_wdata[DATA_W-1:TYPE_W];

    always_comb begin
        wr         = acc_en & acc_we;
        rd         = acc_en & ~acc_we;
        sel_status = (acc_addr == ADDR_W'(OFS_STATUS));
        sel_en     = (acc_addr == ADDR_W'(OFS_ENABLE));
        sel_type   = (acc_addr == ADDR_W'(OFS_TYPE));
        sel_clr    = (acc_addr == ADDR_W'(OFS_CLEAR));
        sel_enm    = (acc_addr == ADDR_W'(OFS_ENABLE_MSK));
        clr_vec    = (wr && sel_clr) ? acc_wdata[NPIN-1:0] : '0;
    end

    always_comb begin
        acc_rdata = '0;
        if (rd) begin
            if (sel_status)           acc_rdata = DATA_W'(status_q);
            else if (sel_en | sel_enm) acc_rdata = DATA_W'(enable_q);
            else if (sel_type)        acc_rdata = DATA_W'(trig_q);
        end
    end

    gpio_irq_cfg #(.NPIN(NPIN)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (wr & sel_en),
        .en_mwr   (wr & sel_enm),
        .type_wr  (wr & sel_type),
        .en_val   (acc_wdata[NPIN-1:0]),
        .en_mask  (acc_wdata[2*NPIN-1:NPIN]),
        .type_val (acc_wdata[TYPE_W-1:0]),
        .enable_o (enable_q),
        .trig_o   (trig_q)
    );

    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        gpio_irq_pin pin_i_u (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_i[n]),
            .is_edge  (trig_q[NPIN+n]),
            .pol      (trig_q[n]),
            .both     (trig_q[2*NPIN+n]),
            .clr      (clr_vec[n]),
            .status_o (status_q[n]),
            .prev_o   (pin_prev[n])
        );
    end

    assign irq_o = |(status_q & enable_q);

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int unsigned NPIN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPIN-1:0]   pin_i,
    input logic [NPIN-1:0]   pin_prev,
    input logic [NPIN-1:0]   status_q,
    input logic [NPIN-1:0]   enable_q,
    input logic [3*NPIN-1:0] trig_q,
    input logic [NPIN-1:0]   clr_vec,
    input logic              irq_o
);

    // R9: line equals the OR of pending and enabled pins
    a_r9_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(status_q & enable_q));

    for (genvar n = 0; n < NPIN; n++) begin : g_chk
        // R3: rising edge in rise mode sets status
        a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_q[NPIN+n] && trig_q[n] && !trig_q[2*NPIN+n] && pin_i[n] && !pin_prev[n])
            |=> status_q[n]);
        // R5: any edge in both-edge mode sets status
        a_r5_both_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_q[NPIN+n] && trig_q[2*NPIN+n] && (pin_i[n] != pin_prev[n]))
            |=> status_q[n]);
        // R6: edge status held without a clear
        a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_q[NPIN+n] && status_q[n] && !clr_vec[n]) |=> status_q[n]);
        // R6: no edge and nothing pending keeps status low
        a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_q[NPIN+n] && !status_q[n] && (pin_i[n] == pin_prev[n])) |=> !status_q[n]);
        // R8: level mode tracks the active level
        a_r8_level_on: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_q[NPIN+n] && (trig_q[n] == pin_i[n])) |=> status_q[n]);
        a_r8_level_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_q[NPIN+n] && (trig_q[n] != pin_i[n])) |=> !status_q[n]);
    end

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_i),
    .pin_prev (pin_prev),
    .status_q (status_q),
    .enable_q (enable_q),
    .trig_q   (trig_q),
    .clr_vec  (clr_vec),
    .irq_o    (irq_o)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin = '0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .irq_o     (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        tick();
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        #1 d = acc_rdata;
        acc_en = 1'b0;
    endtask

    task automatic set_pins(logic [7:0] v);
        pin = v;
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h040, v); check("R1 status", v, 0);
        rd(12'h050, v); check("R1 enable", v, 0);
        rd(12'h060, v); check("R1 type", v, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(12'h050, 32'hFFFF_FFA5);
        wr(12'h060, 32'hFFAB_CDEF);
        rd(12'h050, v); check("R2 enable rw", v, 32'hA5);
        rd(12'h060, v); check("R2 type rw", v, 32'hAB_CDEF);
        wr(12'h044, 32'h0);
        wr(12'h054, 32'h0);
        rd(12'h050, v); check("R2 stray write enable", v, 32'hA5);
        rd(12'h060, v); check("R2 stray write type", v, 32'hAB_CDEF);
        rd(12'h070, v); check("R2 clear reads 0", v, 0);
        rd(12'h100, v); check("R2 unmapped reads 0", v, 0);
        wr(12'h050, 0);
        wr(12'h060, 0);
        tick();
    endtask

    task automatic t_level();
        logic [31:0] v;
        rd(12'h040, v); check("R8 level low all", v, 32'hFF);
        wr(12'h060, 32'h0F);
        tick();
        rd(12'h040, v); check("R8 mixed polarity", v, 32'hF0);
        set_pins(8'h05);
        rd(12'h040, v); check("R8 follows level", v, 32'hF5);
        wr(12'h070, 32'hFF);
        rd(12'h040, v); check("R8 clear no effect", v, 32'hF5);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(12'h060, 32'h00FFFF);
        set_pins(8'h00);
        wr(12'h070, 32'hFF);
        rd(12'h040, v); check("R6 cleared", v, 0);
        set_pins(8'h01);
        rd(12'h040, v); check("R3 rise sets", v, 32'h01);
        set_pins(8'h00);
        rd(12'h040, v); check("R3 fall ignored held", v, 32'h01);
        wr(12'h070, 32'hFE);
        rd(12'h040, v); check("R6 zero bits keep", v, 32'h01);
        wr(12'h070, 32'h01);
        rd(12'h040, v); check("R6 one bit clears", v, 0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(12'h060, 32'h00FF00);
        set_pins(8'hFF);
        rd(12'h040, v); check("R4 rise ignored", v, 0);
        wr(12'h070, 32'hFF);
        set_pins(8'hF0);
        rd(12'h040, v); check("R4 fall sets", v, 32'h0F);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(12'h060, 32'hFFFF00);
        set_pins(8'h00);
        wr(12'h070, 32'hFF);
        rd(12'h040, v); check("R5 cleared", v, 0);
        set_pins(8'h03);
        rd(12'h040, v); check("R5 rises set", v, 32'h03);
        wr(12'h070, 32'hFF);
        set_pins(8'h01);
        rd(12'h040, v); check("R5 fall sets", v, 32'h02);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(12'h060, 32'h00FFFF);
        set_pins(8'h00);
        wr(12'h070, 32'hFF);
        pin = 8'h01;
        wr(12'h070, 32'h01);
        rd(12'h040, v); check("R7 set beats clear", v, 32'h01);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        check("R9 disabled no irq", irq, 0);
        wr(12'h040, 32'h0);
        rd(12'h040, v); check("R2 status read-only", v, 32'h01);
        wr(12'h050, 32'h01);
        check("R9 enabled irq", irq, 1);
        wr(12'h050, 32'h02);
        check("R9 other pin no irq", irq, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(12'h050, 32'h0F);
        wr(12'h850, 32'h30F0);
        rd(12'h050, v); check("R10 masked set", v, 32'h3F);
        wr(12'h850, 32'h0300);
        rd(12'h050, v); check("R10 masked clear", v, 32'h3C);
        wr(12'h850, 32'h00FF);
        rd(12'h850, v); check("R10 zero mask", v, 32'h3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_regs();
        t_level();
        t_rise();
        t_fall();
        t_both();
        t_race();
        t_irq();
        t_mask();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule